// File: doc/BRIEF.md
# Delta-Sigma Converter Frame Reader

This block is a host-side master that pulls one 32-bit result frame out of a serial delta-sigma converter. The converter runs with an external clock and reports its state in-band on its data line. A start request pulls chip select low with the serial clock held low, which keeps the converter on the external clock. The block then watches the data line. A high level means a conversion is still running. A low level means a result is waiting. Once the line goes low, the block produces serial clock pulses and captures one frame bit at each rising edge.

A full read captures 32 bits. The block checks the two leading status bits and then presents the 24-bit result, the sign bit and the five sub-LSB bits with a one-cycle valid strobe, or raises an error strobe in place of valid. A shorter length can be requested. In that case the block raises chip select right after the requested number of clock pulses, which makes the converter drop the frame and start a fresh conversion. A polling timeout reports a converter that never signals ready.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is asserted and after its release, cs_n_o is 1, sck_o is 0 and busy_o, done_o, valid_o, err_o and timeout_o are 0.
- R2: A start_i pulse while idle drives cs_n_o low with sck_o low at that moment. A start_i pulse during a transaction is ignored: it changes neither that transaction's length nor its outcome.
- R3: After a settle delay of HALF_CYC clocks, the block samples sdo_i once per clock. No sck_o pulse is produced while sdo_i is high. The first clock cycle in which sdo_i is low starts the clocking.
- R4: sck_o idles low and each of its phases lasts HALF_CYC system clocks. sdo_i is captured on every rising edge. The first captured bit is frame bit 31 and the last is bit 0.
- R5: A length of 32, 0 or anything above 32 selects a full frame of exactly 32 rising edges of sck_o. After the 32nd falling edge, cs_n_o goes high.
- R6: After a full frame whose bit 31 and bit 30 are both 0, valid_o pulses for one clock. In that cycle result_o equals frame bits 28..5, sign_o equals bit 29 and frac_o equals bits 4..0.
- R7: After a full frame with bit 31 or bit 30 equal to 1, err_o pulses for one clock instead of valid_o. valid_o and err_o are never high together.
- R8: A length L from 1 to 31, latched at start, gives exactly L rising edges of sck_o. cs_n_o rises on the same clock as the L-th falling edge, and neither valid_o nor err_o is asserted for that frame.
- R9: If sdo_i stays high for TIMEOUT_CYC polling clocks, timeout_o and done_o pulse, cs_n_o returns high, and no sck_o edge has been produced.
- R10: done_o pulses for exactly one clock at the end of every transaction, and cs_n_o is high in that clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request one read transaction |
| frame_len_i | input | 6 | Rising edges to produce; 0 or above 32 means 32 |
| sdo_i | input | 1 | Converter data line, synchronous to clk |
| cs_n_o | output | 1 | Active-low chip select |
| sck_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-clock end-of-transaction pulse |
| valid_o | output | 1 | Full frame with good status |
| err_o | output | 1 | Full frame with bad status |
| timeout_o | output | 1 | Converter never reported ready |
| sign_o | output | 1 | Frame bit 29 |
| result_o | output | 24 | Frame bits 28..5 |
| frac_o | output | 5 | Frame bits 4..0 |

## Verification
The bench models a converter that takes a fixed time to convert, shifts on falling edges, and restarts on a completed or aborted frame. Several corner cases are targeted. A read of 1 bit and a read of 31 bits test the abort path: a reader that miscounts gives a wrong edge count, and one that raises chip select late lets the frame complete. Lengths of 0 and 45 must behave as a full read; a design that takes the raw value truncates or overruns. A status bit set to 1 must produce the error strobe; a design that skips the check presents garbage as valid. A start issued mid-frame must leave the frame length unchanged. A converter stuck busy must end in a timeout with no clock edges; a design without the limit hangs. A reset in the middle of a frame must return the pins to idle at once.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int FRAME_W  = 32;
  localparam int LEN_W    = $clog2(FRAME_W + 1);
  localparam int EOC_POS  = 31;
  localparam int STAT_POS = 30;
  localparam int SIGN_POS = 29;
  localparam int RES_MSB  = 28;
  localparam int RES_LSB  = 5;
  localparam int RES_W    = RES_MSB - RES_LSB + 1;
  localparam int FRAC_W   = RES_LSB;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_POLL,
    ST_SHIFT,
    ST_FINISH
  } rd_state_e;
endpackage

// File: rtl/adc_rd_sckgen.sv
module adc_rd_sckgen #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(HALF_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sck_q, sck_d;
  logic          tick;

  assign tick = run_i && (cnt_q == CW'(HALF_CYC - 1));

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run_i) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck_o  = sck_q;
  assign rise_o = tick & ~sck_q;
  assign fall_o = tick & sck_q;
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int FW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     smp_i,
  input  logic                     sdo_i,
  output logic [FW-1:0]            frame_o,
  output logic [$clog2(FW+1)-1:0]  nbits_o
);
  localparam int BW = $clog2(FW + 1);

  logic [FW-1:0] sh_q, sh_d;
  logic [BW-1:0] nb_q, nb_d;

  always_comb begin
    sh_d = sh_q;
    nb_d = nb_q;
    if (clr_i) begin
      sh_d = '0;
      nb_d = '0;
    end else if (smp_i) begin
      sh_d = {sh_q[FW-2:0], sdo_i};
      nb_d = nb_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      nb_q <= '0;
    end else if (clr_i || smp_i) begin
      sh_q <= sh_d;
      nb_q <= nb_d;
    end
  end

  assign frame_o = sh_q;
  assign nbits_o = nb_q;
endmodule

// File: rtl/adc_rd_fsm.sv
module adc_rd_fsm
  import adc_rd_pkg::*;
#(
  parameter int HALF_CYC    = 4,
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             sdo_i,
  input  logic             fall_i,
  input  logic [LEN_W-1:0] nbits_i,
  input  logic [1:0]       stat_i,
  output logic             cs_n_o,
  output logic             run_o,
  output logic             clr_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             valid_o,
  output logic             err_o,
  output logic             timeout_o
);
  localparam int WW = $clog2(TIMEOUT_CYC + HALF_CYC + 1);

  rd_state_e        st_q, st_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [WW-1:0]    wcnt_q, wcnt_d;
  logic             to_q, to_d;
  logic             cs_n_q, cs_n_d;
  logic             full_frame, stat_ok;

  always_comb begin
    st_d   = st_q;
    len_d  = len_q;
    wcnt_d = wcnt_q;
    to_d   = to_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_SETUP;
          wcnt_d = '0;
          to_d   = 1'b0;
          if (len_i == '0 || len_i > LEN_W'(FRAME_W)) len_d = LEN_W'(FRAME_W);
          else                                        len_d = len_i;
        end
      end
      ST_SETUP: begin
        if (wcnt_q == WW'(HALF_CYC - 1)) begin
          st_d   = ST_POLL;
          wcnt_d = '0;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      ST_POLL: begin
        if (!sdo_i) begin
          st_d = ST_SHIFT;
        end else if (wcnt_q == WW'(TIMEOUT_CYC - 1)) begin
          st_d = ST_FINISH;
          to_d = 1'b1;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      ST_SHIFT: begin
        if (fall_i && nbits_i == len_q) st_d = ST_FINISH;
      end
      ST_FINISH: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
    cs_n_d = (st_d == ST_IDLE) || (st_d == ST_FINISH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      len_q  <= LEN_W'(FRAME_W);
      wcnt_q <= '0;
      to_q   <= 1'b0;
      cs_n_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      len_q  <= len_d;
      wcnt_q <= wcnt_d;
      to_q   <= to_d;
      cs_n_q <= cs_n_d;
    end
  end

  assign full_frame = (len_q == LEN_W'(FRAME_W));
  assign stat_ok    = (stat_i == 2'b00);

  assign cs_n_o    = cs_n_q;
  assign run_o     = (st_q == ST_SHIFT);
  assign clr_o     = (st_q == ST_IDLE) && start_i;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = (st_q == ST_FINISH);
  assign timeout_o = done_o && to_q;
  assign valid_o   = done_o && !to_q && full_frame && stat_ok;
  assign err_o     = done_o && !to_q && full_frame && !stat_ok;
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_rd_pkg::*;
#(
  parameter int HALF_CYC    = 4,
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  input  logic              sdo_i,
  output logic              cs_n_o,
  output logic              sck_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              valid_o,
  output logic              err_o,
  output logic              timeout_o,
  output logic              sign_o,
  output logic [RES_W-1:0]  result_o,
  output logic [FRAC_W-1:0] frac_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic               run, rise, fall, clr;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   nbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  adc_rd_fsm #(
    .HALF_CYC    (HALF_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start_i),
    .len_i     (frame_len_i),
    .sdo_i     (sdo_i),
    .fall_i    (fall),
    .nbits_i   (nbits),
    .stat_i    (frame[EOC_POS:STAT_POS]),
    .cs_n_o    (cs_n_o),
    .run_o     (run),
    .clr_o     (clr),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .valid_o   (valid_o),
    .err_o     (err_o),
    .timeout_o (timeout_o)
  );

  adc_rd_sckgen #(
    .HALF_CYC (HALF_CYC)
  ) u_sck (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (run),
    .sck_o  (sck_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  adc_rd_shift #(
    .FW (FRAME_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr_i   (clr),
    .smp_i   (rise),
    .sdo_i   (sdo_i),
    .frame_o (frame),
    .nbits_o (nbits)
  );

  assign sign_o   = frame[SIGN_POS];
  assign result_o = frame[RES_MSB:RES_LSB];
  assign frac_o   = frame[FRAC_W-1:0];
endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk #(
  parameter int FW = 32
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n_o,
  input logic sck_o,
  input logic done_o,
  input logic valid_o,
  input logic err_o,
  input logic timeout_o
);
  logic       cs_q, sck_q;
  logic [6:0] rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      sck_q    <= 1'b0;
      rise_cnt <= '0;
    end else begin
      cs_q  <= cs_n_o;
      sck_q <= sck_o;
      if (cs_q && !cs_n_o)      rise_cnt <= '0;
      else if (!sck_q && sck_o) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  AST_CS_FALL_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> !sck_o); // R2
  AST_SCK_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sck_o); // R4
  AST_RISE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rise_cnt <= 7'(FW)); // R5
  AST_VALID_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (rise_cnt == 7'(FW))); // R6
  AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && err_o)); // R7
  AST_TRUNC_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && rise_cnt != 7'(FW)) |-> !(valid_o || err_o)); // R8
  AST_TIMEOUT_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (rise_cnt == '0)); // R9
  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cs_n_o); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
endmodule

bind adc_frame_reader adc_rd_chk #(.FW(32)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n_o    (cs_n_o),
  .sck_o     (sck_o),
  .done_o    (done_o),
  .valid_o   (valid_o),
  .err_o     (err_o),
  .timeout_o (timeout_o)
);

// File: tb/adc_frame_reader_bench.sv
module adc_frame_reader_bench;
  localparam int HALF = 3;
  localparam int TO   = 300;
  localparam int CONV = 120;
  localparam int NVEC = 9;

  // {len[5:0], bit30, sign, result[23:0], frac[4:0]}
  localparam logic [36:0] VEC [NVEC] = '{
    {6'd32, 1'b0, 1'b1, 24'hABCDEF, 5'h15},
    {6'd32, 1'b0, 1'b0, 24'h000001, 5'h00},
    {6'd32, 1'b1, 1'b1, 24'h123456, 5'h1F},
    {6'd1,  1'b0, 1'b1, 24'hFFFFFF, 5'h1F},
    {6'd31, 1'b0, 1'b0, 24'h0F0F0F, 5'h03},
    {6'd16, 1'b1, 1'b0, 24'h3C3C3C, 5'h11},
    {6'd0,  1'b0, 1'b0, 24'hFEDCBA, 5'h0A},
    {6'd45, 1'b0, 1'b1, 24'h800000, 5'h01},
    {6'd32, 1'b0, 1'b0, 24'h7FFFFF, 5'h1E}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [5:0]  len_in;
  logic        sdo;
  logic        cs_n, sck, busy, done, valid, err, tmo, sign;
  logic [23:0] result;
  logic [4:0]  frac;

  int total = 0;
  int bad   = 0;

  logic [31:0] nxt_frame;
  logic [31:0] mshift;
  logic        mdata, mdead, psck, pcs;
  int          mcnt, mfall;
  int          rises, hcur, hlast;

  logic        c_valid, c_err, c_tmo, c_sign, c_cs;
  logic [23:0] c_res;
  logic [4:0]  c_frac;
  int          c_rises, c_cycles;

  always #10 clk = ~clk;

  adc_frame_reader #(.HALF_CYC(HALF), .TIMEOUT_CYC(TO)) u_adc_frame_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start), .frame_len_i(len_in),
    .sdo_i(sdo), .cs_n_o(cs_n), .sck_o(sck), .busy_o(busy), .done_o(done),
    .valid_o(valid), .err_o(err), .timeout_o(tmo), .sign_o(sign),
    .result_o(result), .frac_o(frac)
  );

  // converter model: shifts on falling SCK, restarts on frame end or abort
  assign sdo = mdead ? 1'b1 : cs_n ? 1'b1 : mdata ? mshift[31] : (mcnt != 0);

  always @(negedge clk) begin
    logic do_fall, end_frame, abort;
    if (!rst_n) begin
      mcnt <= CONV; mdata <= 1'b0; mfall <= 0; psck <= 1'b0; pcs <= 1'b1;
    end else begin
      do_fall   = psck && !sck && mdata;
      end_frame = do_fall && (mfall == 31);
      abort     = !pcs && cs_n && mdata && !end_frame;
      if (!psck && sck && !cs_n && !mdata && mcnt == 0) begin
        mdata <= 1'b1; mshift <= nxt_frame; mfall <= 0;
      end else if (end_frame || abort) begin
        mdata <= 1'b0; mcnt <= CONV;
      end else if (do_fall) begin
        mshift <= mshift << 1; mfall <= mfall + 1;
      end else if (mcnt > 0) begin
        mcnt <= mcnt - 1;
      end
      psck <= sck;
      pcs  <= cs_n;
    end
  end

  // edge and phase monitor
  always @(negedge clk) begin
    if (!psck && sck) rises <= rises + 1;
    if (sck) hcur <= hcur + 1;
    else if (psck) begin hlast <= hcur; hcur <= 0; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input logic [5:0] len, input logic [31:0] frame,
                         input bit extra_start, input bit poll_chk);
    int base;
    @(negedge clk);
    nxt_frame = frame; len_in = len; start = 1'b1;
    @(negedge clk);
    start = 1'b0; base = rises; c_cycles = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done) break;
      if (extra_start && i == 5) begin start = 1'b1; len_in = 6'd5; end
      if (extra_start && i == 6) start = 1'b0;
      if (poll_chk && i == 40)
        chk(!cs_n && (rises == base), "R3", "no sck while converter busy",
            rises - base, 0);
      @(negedge clk);
      c_cycles = i + 1;
    end
    c_valid = valid; c_err = err; c_tmo = tmo; c_sign = sign;
    c_res = result; c_frac = frac; c_cs = cs_n; c_rises = rises - base;
    chk(done == 1'b1, "R10", "done reached", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done single pulse", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rises = 0; hcur = 0; hlast = 0;
    start = 1'b0; len_in = 6'd32; nxt_frame = '0; mdead = 1'b0; mshift = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n && !sck && !busy && !done && !valid && !err && !tmo, "R1",
        "pins during reset", {cs_n, sck, busy, done, valid, err, tmo}, 7'b1000000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n && !sck && !busy, "R1", "pins after reset", {cs_n, sck, busy}, 3'b100);

    for (int v = 0; v < NVEC; v++) begin
      logic [5:0]  l;
      logic        b30, sg, full;
      logic [23:0] d;
      logic [4:0]  f;
      int          er;
      {l, b30, sg, d, f} = VEC[v];
      full = (l == 0) || (l >= 32);
      er = full ? 32 : int'(l);
      run_txn(l, {1'b0, b30, sg, d, f}, 1'b0, v == 0);
      chk(c_rises == er, full ? "R5" : "R8", "sck rising edges", c_rises, er);
      chk(c_valid == (full && !b30), full ? "R6" : "R8", "valid strobe",
          c_valid, full && !b30);
      chk(c_err == (full && b30), "R7", "err strobe", c_err, full && b30);
      chk(c_cs == 1'b1, "R10", "cs high at done", c_cs, 1);
      if (full && !b30) begin
        chk(c_res == d, "R6", "result field", c_res, d);
        chk(c_sign == sg, "R6", "sign bit", c_sign, sg);
        chk(c_frac == f, "R6", "sub-lsb bits", c_frac, f);
      end
      if (er > 1) chk(hlast == HALF, "R4", "sck high phase", hlast, HALF);
    end

    // start pulse mid-frame must be ignored
    run_txn(6'd32, {2'b00, 1'b1, 24'h5A5A5A, 5'h07}, 1'b1, 1'b0);
    chk(c_rises == 32, "R2", "length kept on extra start", c_rises, 32);
    chk(c_valid && c_res == 24'h5A5A5A, "R2", "result kept on extra start",
        c_res, 24'h5A5A5A);

    // dead converter: line stays high
    mdead = 1'b1;
    run_txn(6'd32, 32'h0, 1'b0, 1'b0);
    chk(c_tmo == 1'b1, "R9", "timeout strobe", c_tmo, 1);
    chk(c_rises == 0 && !c_valid && !c_err, "R9", "no clocks on timeout",
        c_rises, 0);
    chk(c_cycles >= TO, "R9", "timeout wait length", c_cycles, TO);
    mdead = 1'b0;

    // reset in mid-frame
    @(negedge clk);
    nxt_frame = 32'h0; len_in = 6'd32; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (sck) break;
      @(negedge clk);
    end
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cs_n && !sck && !busy, "R1", "mid-frame reset idles pins",
        {cs_n, sck, busy}, 3'b100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_txn(6'd32, {2'b00, 1'b0, 24'h0BADC0, 5'h12}, 1'b0, 1'b0);
    chk(c_valid && c_res == 24'h0BADC0 && !c_sign, "R6", "read after reset",
        c_res, 24'h0BADC0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule